// File: doc/BRIEF.md
# SDRAM Address Multiplexer

This block turns a flat host byte address into the values placed on the shared address pins and the two bank pins of a 16-bit or 32-bit SDRAM. The controller that sequences commands tells the block which phase it is in (activate, read/write, or mode-register load). The block then picks the row field or the column field out of the host address and drives it onto the low address pins. The bank field is always routed to the separate bank outputs, which sit on the two physical pins above the row bits.

Two address layouts can be chosen at run time. With row-bank-column, the bank bits sit just above the column bits. With bank-row-column, the bank bits are the top bits of the address. The device width selects where the column field starts: byte bit 1 for a 16-bit device, byte bit 2 for a 32-bit device. In the 32-bit case every field moves up by one bit. Host address bits lower than the column field are ignored. The pin outputs are registered, so they follow the inputs one clock later.

Top module: `sdram_addr_mux`

## Requirements
- R1: While rst_ni is low, a_o and ba_o are all zero.
- R2: a_o and ba_o show the mapping of the inputs sampled at the previous rising clock edge.
- R3: When wide_i=0 (16-bit device), the 9-bit column field is addr_i[9:1] and addr_i[0] has no effect on any output.
- R4: When wide_i=1 (32-bit device), every field starts one bit higher than in R5/R6, the column is addr_i[10:2], addr_i[1:0] have no effect, and any field bit above addr_i[23] reads as zero.
- R5: When layout_i=0 (row-bank-column) and wide_i=0, the bank field is addr_i[11:10] and the row field is addr_i[23:12].
- R6: When layout_i=1 (bank-row-column) and wide_i=0, the row field is addr_i[21:10] and the bank field is addr_i[23:22].
- R7: When phase_i=2'b00 (activate), a_o[11:0] carries the 12-bit row field.
- R8: When phase_i=2'b01 (read/write), a_o[8:0] carries the column field, a_o[10] carries ap_i, and a_o[11] and a_o[9] are zero.
- R9: In every phase, ba_o carries the bank field of the selected layout.
- R10: When phase_i[1]=1 (mode load, codes 2'b10 and 2'b11), a_o carries the row field. A mode value v is therefore placed by addressing v<<12 in row-bank-column layout or v<<10 in bank-row-column layout (16-bit device).
- R11: ap_i has no effect on any output outside the read/write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Host byte address |
| layout_i | input | 1 | 0: row-bank-column, 1: bank-row-column |
| wide_i | input | 1 | 0: 16-bit device, 1: 32-bit device |
| phase_i | input | 2 | 00 activate, 01 read/write, 1x mode load |
| ap_i | input | 1 | Auto-precharge flag for the read/write phase |
| a_o | output | 12 | Multiplexed address pins |
| ba_o | output | 2 | Bank pins |

## Verification
The bench builds the block with its default parameters: a 24-bit host address, a 12-bit row, a 9-bit column and a 2-bit bank. With these widths both layouts and both device widths can be reached, including the 32-bit case where the top row bit or bank bit falls beyond the host address and must read as zero. Directed patterns place the mode values at shift 12 and at shift 10, walk single bits across the field boundaries, and toggle the ignored low bits and the auto-precharge flag. Randomized traffic across all phase codes then fills in the remaining combinations.

// File: rtl/sdram_amux_pkg.sv
package sdram_amux_pkg;
  typedef enum logic [1:0] {
    PH_ACT  = 2'b00,
    PH_RW   = 2'b01,
    PH_MODE = 2'b10,
    PH_MRSV = 2'b11
  } phase_e;

  typedef enum logic {
    LAY_RBC = 1'b0,
    LAY_BRC = 1'b1
  } layout_e;
endpackage

// File: rtl/sdram_amux_fields.sv
module sdram_amux_fields #(
  parameter int HADDR_W = 24,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2
) (
  input  logic [HADDR_W-1:0] addr_i,
  input  logic               layout_i,
  input  logic               wide_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [COL_W-1:0]   col_o,
  output logic [BANK_W-1:0]  bank_o
);
  import sdram_amux_pkg::*;

  localparam int EXT_W = 2 + COL_W + BANK_W + ROW_W;

  logic [EXT_W-1:0] ext;
  logic [4:0]       off;

  generate
    if (HADDR_W >= EXT_W) begin : g_trunc
      assign ext = addr_i[EXT_W-1:0];
    end else begin : g_pad
      assign ext = {{(EXT_W-HADDR_W){1'b0}}, addr_i};
    end
  endgenerate

  // column lsb: byte bit 1 (16-bit) or 2 (32-bit)
  assign off = wide_i ? 5'd2 : 5'd1;

  always_comb begin
    col_o = ext[off +: COL_W];
    if (layout_e'(layout_i) == LAY_RBC) begin
      bank_o = ext[(off + COL_W) +: BANK_W];
      row_o  = ext[(off + COL_W + BANK_W) +: ROW_W];
    end else begin
      row_o  = ext[(off + COL_W) +: ROW_W];
      bank_o = ext[(off + COL_W + ROW_W) +: BANK_W];
    end
  end
endmodule

// File: rtl/sdram_amux_drive.sv
module sdram_amux_drive #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int AP_PIN = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        phase_i,
  input  logic              ap_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ROW_W-1:0]  a_o,
  output logic [BANK_W-1:0] ba_o
);
  import sdram_amux_pkg::*;

  logic [ROW_W-1:0] col_pins;
  logic [ROW_W-1:0] a_d;

  for (genvar i = 0; i < ROW_W; i++) begin : g_colpin
    if (i < COL_W) begin : g_col
      assign col_pins[i] = col_i[i];
    end else if (i == AP_PIN) begin : g_ap
      assign col_pins[i] = ap_i;
    end else begin : g_zero
      assign col_pins[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (phase_e'(phase_i))
      PH_RW:   a_d = col_pins;
      default: a_d = row_i;  // activate and mode load use the row field
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o  <= '0;
      ba_o <= '0;
    end else begin
      a_o  <= a_d;
      ba_o <= bank_i;
    end
  end

  AST_RST_PINS_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (a_o == '0 && ba_o == '0)); // R1
endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux #(
  parameter int HADDR_W = 24,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic               layout_i,
  input  logic               wide_i,
  input  logic [1:0]         phase_i,
  input  logic               ap_i,
  output logic [ROW_W-1:0]   a_o,
  output logic [BANK_W-1:0]  ba_o
);
  localparam int AP_PIN = 10;

  logic [ROW_W-1:0]  row_f;
  logic [COL_W-1:0]  col_f;
  logic [BANK_W-1:0] bank_f;

  sdram_amux_fields #(
    .HADDR_W(HADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
  ) u_fields (
    .addr_i   (addr_i),
    .layout_i (layout_i),
    .wide_i   (wide_i),
    .row_o    (row_f),
    .col_o    (col_f),
    .bank_o   (bank_f)
  );

  sdram_amux_drive #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_PIN(AP_PIN)
  ) u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_i),
    .ap_i    (ap_i),
    .row_i   (row_f),
    .col_i   (col_f),
    .bank_i  (bank_f),
    .a_o     (a_o),
    .ba_o    (ba_o)
  );

  // set once an edge has passed out of reset, so $past sees valid inputs
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RBC_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(layout_i == 1'b0 && wide_i == 1'b0))
      |-> ba_o == $past(addr_i[11:10])); // R5
  AST_BRC_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(layout_i == 1'b1 && wide_i == 1'b0))
      |-> ba_o == $past(addr_i[23:22])); // R6
  AST_RBC_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(layout_i == 1'b0 && wide_i == 1'b0 && phase_i == 2'b00))
      |-> a_o == $past(addr_i[23:12])); // R7
  AST_COL_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(phase_i == 2'b01))
      |-> (a_o[11] == 1'b0 && a_o[9] == 1'b0 && a_o[10] == $past(ap_i))); // R8
  AST_COL16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(phase_i == 2'b01 && wide_i == 1'b0))
      |-> a_o[8:0] == $past(addr_i[9:1])); // R3
  AST_MODE_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(phase_i[1] && layout_i == 1'b1 && wide_i == 1'b0))
      |-> a_o == $past(addr_i[21:10])); // R10
endmodule

// File: tb/sdram_addr_mux_test.sv
module sdram_addr_mux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        lay = 1'b0, wide = 1'b0, ap = 1'b0;
  logic [1:0]  ph = 2'b00;
  logic [11:0] a_pins;
  logic [1:0]  ba_pins;

  int checks = 0, errors = 0;
  bit done = 0;
  bit pend = 0;
  int exp_a, exp_b;
  string pend_tag;

  sdram_addr_mux uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .layout_i(lay), .wide_i(wide),
    .phase_i(ph), .ap_i(ap), .a_o(a_pins), .ba_o(ba_pins)
  );

  always #10 clk = ~clk;

  function automatic void model(input longint a, input int l, input int w,
                                input int p, input int f,
                                output int pins, output int bk);
    int o = w ? 2 : 1;
    int col, row;
    col = int'((a >> o) & 511);
    if (l == 0) begin
      bk  = int'((a >> (o + 9)) & 3);
      row = int'((a >> (o + 11)) & 4095);
    end else begin
      row = int'((a >> (o + 9)) & 4095);
      bk  = int'((a >> (o + 21)) & 3);
    end
    if (p == 1) pins = col | (f << 10);
    else        pins = row;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      check(int'(a_pins), exp_a, {pend_tag, " a_o"});
      check(int'(ba_pins), exp_b, {pend_tag, " ba_o"});
    end
  endtask

  // at negedge: check result of previous drive, then drive new inputs
  task automatic step(input logic [23:0] na, input bit nl, input bit nw,
                      input logic [1:0] np, input bit nf, input string tag);
    @(negedge clk);
    compare_pending();
    addr = na; lay = nl; wide = nw; ph = np; ap = nf;
    model(longint'(na), int'(nl), int'(nw), int'(np), int'(nf), exp_a, exp_b);
    pend_tag = {tag, " R2 R9"};
    pend = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    addr = 24'hFFFFFF; ph = 2'b01; ap = 1'b1; lay = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(a_pins), 0, "R1 reset a_o");
    check(int'(ba_pins), 0, "R1 reset ba_o");
    rst_n = 1'b1;

    // R10: mode value 0x33 at shift 12 (RBC) and shift 10 (BRC)
    step(24'(24'h33 << 12), 1'b0, 1'b0, 2'b10, 1'b0, "R10 R5 mode rbc");
    step(24'(24'h33 << 10), 1'b1, 1'b0, 2'b10, 1'b0, "R10 R6 mode brc");
    step(24'(24'h33 << 10), 1'b1, 1'b0, 2'b11, 1'b1, "R10 R11 mode code3");
    // R5 / R6 / R7 field boundaries
    step(24'h000C00, 1'b0, 1'b0, 2'b00, 1'b0, "R5 R7 rbc bank bits");
    step(24'hFFF000, 1'b0, 1'b0, 2'b00, 1'b1, "R5 R7 R11 rbc row");
    step(24'hC00000, 1'b1, 1'b0, 2'b00, 1'b0, "R6 R7 brc bank");
    step(24'h3FFC00, 1'b1, 1'b0, 2'b00, 1'b1, "R6 R7 R11 brc row");
    // R3 / R8 column phase
    step(24'h0003FE, 1'b0, 1'b0, 2'b01, 1'b0, "R3 R8 col16");
    step(24'h0003FF, 1'b0, 1'b0, 2'b01, 1'b1, "R3 R8 col16 bit0 ap");
    step(24'h000001, 1'b1, 1'b0, 2'b01, 1'b0, "R3 R8 bit0 only");
    step(24'hFFFFFF, 1'b1, 1'b0, 2'b01, 1'b0, "R8 spare pins low");
    // R4 32-bit layouts
    step(24'h0007FC, 1'b0, 1'b1, 2'b01, 1'b1, "R4 R8 col32");
    step(24'h000003, 1'b0, 1'b1, 2'b01, 1'b0, "R4 low bits ignored");
    step(24'hFFFFFF, 1'b0, 1'b1, 2'b00, 1'b0, "R4 R5 rbc32 row top zero");
    step(24'hFFFFFF, 1'b1, 1'b1, 2'b00, 1'b0, "R4 R6 brc32 bank top zero");
    step(24'h800000, 1'b1, 1'b1, 2'b10, 1'b0, "R4 R10 brc32 mode");

    for (int i = 0; i < 400; i++) begin
      step(24'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), "R3 R4 R5 R6 R7 R8 R10 R11 random");
    end
    @(negedge clk);
    compare_pending();
    pend = 0;

    // R1: asynchronous reset clears pins mid-run
    addr = 24'hABCDEF; ph = 2'b00;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(int'(a_pins), 0, "R1 async reset a_o");
    check(int'(ba_pins), 0, "R1 async reset ba_o");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule